// File: doc/BRIEF.md
# Reverse-Order CRC-16 Accumulator

This block produces the ordinary CRC-16 of a message even though the message bytes reach it backwards. The first byte to arrive is the last byte of the message. The CRC uses generator 0x1021, starts from zero and applies no final inversion. Bytes come in frames of up to seven lanes. Each frame carries a count of the lanes that hold data, and a flag marks the final frame of the message.

Each byte is absorbed by running the register backwards eight bit steps and then folding the byte into its upper half. Once the final frame has been consumed, the register is run forward through one zero byte for every byte received. The result is the value a normal forward shift register would have produced on the message in its natural order. The block performs one bit step per clock.

A start pulse clears the block and opens a new message. The result is presented with a one-cycle done strobe and stays on the output until the next start pulse.

Top module: `rcrc_accum`

## Requirements
- R1: `crc_o` equals the CRC-16 of the message in natural order: polynomial 0x1021, processed MSB first, initial value 0, no final XOR. Natural order is the reverse of arrival order. Arrival order is lane 0 upward within a frame, and frames in the order they are accepted. Example: arrival 39 38 37 36 35 34 33 32 31 gives 0x31C3.
- R2: Byte lane j of `frm_data_i` occupies bits [8j+7:8j]. Lanes 0 to count-1 carry data, and lanes at or above `frm_count_i` have no effect on the result.
- R3: A frame is taken on a rising edge where `frm_valid_i` and `frm_ready_o` are both high and `start_i` is low.
- R4: `frm_ready_o` drops in the cycle after a frame with a nonzero count, or a final frame, is taken. It stays low while bytes or the zero phase are processed. It also stays low after done, until a start pulse.
- R5: Let N be the total byte count, with N ≥ 1, and let k be the count of the final frame. `done_o` rises exactly 8k+8N+1 cycles after the edge that takes the final frame, and not one cycle earlier.
- R6: `done_o` is high for exactly one cycle. `crc_o` keeps its value from then until the next start pulse.
- R7: `start_i` aborts any message in progress and clears the state. In the next cycle `crc_o` is 0, `done_o` is 0 and `frm_ready_o` is 1. A frame offered in the same cycle as `start_i` is discarded.
- R8: A message whose first frame is a final frame with count 0 yields `crc_o` = 0, with `done_o` high two cycles after that frame is taken.
- R9: After reset, `frm_ready_o` is 1, `done_o` is 0 and `crc_o` is 0.
- R10: A non-final frame with count 0 is taken without effect, and `frm_ready_o` is still high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear state and begin a new message |
| frm_valid_i | input | 1 | A frame is offered |
| frm_ready_o | output | 1 | Block can take a frame |
| frm_data_i | input | 56 | Seven byte lanes, lane 0 in bits [7:0] |
| frm_count_i | input | 3 | Number of valid lanes, 0 to 7 |
| frm_last_i | input | 1 | Frame is the final one of the message |
| crc_o | output | 16 | Resulting CRC, held until the next start |
| done_o | output | 1 | One-cycle strobe when `crc_o` is loaded |

## Verification
The clear function can coincide with the frame intake. The bench raises `start_i` in the same cycle that it offers a non-empty final frame. It judges the outcome by finding `frm_ready_o` still high afterwards, and by a following empty message that returns zero; either check would fail if the offered frame had been absorbed. A second case lands `start_i` in the middle of byte absorption, and a fresh message is then checked against the arithmetic model.

// File: rtl/rcrc_pkg.sv
package rcrc_pkg;

  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_INV,
    ST_ZERO,
    ST_FIN,
    ST_HOLD
  } ctl_state_t;

  // One backward bit step: undoes one forward shift of the generator.
  function automatic logic [CRC_W-1:0] inv_bit(input logic [CRC_W-1:0] r,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] rev_poly;
    rev_poly = {1'b1, poly[CRC_W-1:1]};
    return r[0] ? ((r >> 1) ^ rev_poly) : (r >> 1);
  endfunction

  // One forward bit step with a zero input bit.
  function automatic logic [CRC_W-1:0] fwd_bit(input logic [CRC_W-1:0] r,
                                               input logic [CRC_W-1:0] poly);
    return r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
  endfunction

endpackage

// File: rtl/rcrc_lane_buf.sv
module rcrc_lane_buf #(
  parameter int LANES = 7,
  parameter int CNT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      load,
  input  logic [8*LANES-1:0]        load_data,
  input  logic [CNT_W-1:0]          load_cnt,
  input  logic                      load_last,
  input  logic                      take,
  output logic [7:0]                cur_byte,
  output logic                      at_final_lane,
  output logic                      frame_last
);
  localparam int SLOTS = 1 << CNT_W;

  logic [8*LANES-1:0] data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   idx_q;
  logic               last_q;
  logic [7:0]         lane_arr [SLOTS];
  logic [CNT_W:0]     idx_nx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    if (g < LANES) begin : g_real
      assign lane_arr[g] = data_q[8*g +: 8];
    end else begin : g_pad
      assign lane_arr[g] = '0;
    end
  end

  assign cur_byte      = lane_arr[idx_q];
  assign idx_nx        = {1'b0, idx_q} + (CNT_W+1)'(1);
  assign at_final_lane = (idx_nx == {1'b0, cnt_q});
  assign frame_last    = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      data_q <= load_data;
      cnt_q  <= load_cnt;
      idx_q  <= '0;
      last_q <= load_last;
    end else if (take) begin
      idx_q  <= idx_nx[CNT_W-1:0];
    end
  end

  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (idx_q < cnt_q)); // R2

endmodule

// File: rtl/rcrc_shift_core.sv
module rcrc_shift_core import rcrc_pkg::*; #(
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inv_en,
  input  logic             absorb,
  input  logic [7:0]       absorb_byte,
  input  logic             fwd_en,
  output logic [CRC_W-1:0] state
);
  logic [CRC_W-1:0] reg_q;
  logic [CRC_W-1:0] inv_nx;

  always_comb begin
    inv_nx = inv_bit(reg_q, POLY);
    if (absorb) inv_nx = inv_nx ^ {absorb_byte, {(CRC_W-BYTE_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (clr)    reg_q <= '0;
    else if (inv_en) reg_q <= inv_nx;
    else if (fwd_en) reg_q <= fwd_bit(reg_q, POLY);
  end

  assign state = reg_q;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_en && fwd_en)); // R1
  AST_ABSORB_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    absorb |-> inv_en); // R1

endmodule

// File: rtl/rcrc_len_ctr.sv
module rcrc_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic             len_zero,
  output logic             len_one
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (clr)  len_q <= '0;
    else if (inc)  len_q <= len_q + LEN_W'(1);
    else if (dec)  len_q <= len_q - LEN_W'(1);
  end

  assign len_zero = (len_q == '0);
  assign len_one  = (len_q == LEN_W'(1));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (len_q != '1)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (len_q != '0)); // R5
  AST_EXCLUSIVE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R5

endmodule

// File: rtl/rcrc_accum.sv
module rcrc_accum import rcrc_pkg::*; #(
  parameter int               LANES = 7,
  parameter int               LEN_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  localparam int              CNT_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 frm_valid_i,
  output logic                 frm_ready_o,
  input  logic [8*LANES-1:0]   frm_data_i,
  input  logic [CNT_W-1:0]     frm_count_i,
  input  logic                 frm_last_i,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 done_o
);
  ctl_state_t       state_q, state_d;
  logic [2:0]       bit_q;
  logic [CRC_W-1:0] crc_q;
  logic             done_q;

  // named internal events
  logic             accept_evt;
  logic             inv_en, fwd_en;
  logic             absorb_evt;
  logic             len_inc, len_dec;
  logic             fin_evt;

  logic [7:0]       cur_byte;
  logic             at_final_lane, frame_last;
  logic             len_zero, len_one;
  logic [CRC_W-1:0] core_state;

  assign frm_ready_o = (state_q == ST_WAIT);
  assign accept_evt  = frm_valid_i && frm_ready_o && !start_i;
  assign fin_evt     = (state_q == ST_FIN);

  always_comb begin
    state_d    = state_q;
    inv_en     = 1'b0;
    fwd_en     = 1'b0;
    absorb_evt = 1'b0;
    len_inc    = 1'b0;
    len_dec    = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (accept_evt) begin
          if (frm_count_i != '0) state_d = ST_INV;
          else if (frm_last_i)   state_d = ST_ZERO;
        end
      end
      ST_INV: begin
        inv_en = 1'b1;
        if (bit_q == 3'd7) begin
          absorb_evt = 1'b1;
          len_inc    = 1'b1;
          if (at_final_lane) state_d = frame_last ? ST_ZERO : ST_WAIT;
        end
      end
      ST_ZERO: begin
        if (len_zero) begin
          state_d = ST_FIN;
        end else begin
          fwd_en = 1'b1;
          if (bit_q == 3'd7) begin
            len_dec = 1'b1;
            if (len_one) state_d = ST_FIN;
          end
        end
      end
      ST_FIN:  state_d = ST_HOLD;
      ST_HOLD: state_d = ST_HOLD;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      bit_q   <= '0;
      crc_q   <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_WAIT;
      bit_q   <= '0;
      crc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (inv_en || fwd_en) bit_q <= bit_q + 3'd1;
      if (fin_evt) crc_q <= core_state;
      done_q  <= fin_evt;
    end
  end

  rcrc_lane_buf #(.LANES(LANES), .CNT_W(CNT_W)) u_lanes (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (start_i),
    .load          (accept_evt),
    .load_data     (frm_data_i),
    .load_cnt      (frm_count_i),
    .load_last     (frm_last_i),
    .take          (absorb_evt),
    .cur_byte      (cur_byte),
    .at_final_lane (at_final_lane),
    .frame_last    (frame_last)
  );

  rcrc_shift_core #(.POLY(POLY)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (start_i),
    .inv_en      (inv_en),
    .absorb      (absorb_evt),
    .absorb_byte (cur_byte),
    .fwd_en      (fwd_en),
    .state       (core_state)
  );

  rcrc_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_i),
    .inc      (len_inc),
    .dec      (len_dec),
    .len_zero (len_zero),
    .len_one  (len_one)
  );

  assign crc_o  = crc_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !fin_evt) |=> $stable(crc_o)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (crc_o == '0 && frm_ready_o && !done_o)); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && (frm_count_i != '0 || frm_last_i)) |=> !frm_ready_o); // R4
  AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && frm_count_i == '0 && !frm_last_i) |=> frm_ready_o); // R10

endmodule

// File: tb/test_rcrc_accum.sv
`timescale 1ns/1ps
module test_rcrc_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        frm_valid_i = 1'b0;
  logic        frm_ready_o;
  logic [55:0] frm_data_i = '0;
  logic [2:0]  frm_count_i = '0;
  logic        frm_last_i = 1'b0;
  logic [15:0] crc_o;
  logic        done_o;

  int n_vec = 0;
  int n_bad = 0;
  int unsigned lfsr = 32'h1357_9BDF;
  logic [7:0] msg_a [0:63];

  always #4 clk = ~clk;

  rcrc_accum i_rcrc_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .frm_valid_i(frm_valid_i), .frm_ready_o(frm_ready_o),
    .frm_data_i(frm_data_i), .frm_count_i(frm_count_i),
    .frm_last_i(frm_last_i), .crc_o(crc_o), .done_o(done_o)
  );

  function automatic int unsigned next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // forward CRC over the natural order (reverse of arrival)
  function automatic logic [15:0] model_crc(input int n);
    logic [15:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      c = c ^ {msg_a[i], 8'h00};
      for (int b = 0; b < 8; b++)
        c = c[15] ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the taking edge
  task automatic send_frame(input logic [55:0] d, input int cnt, input bit lst);
    frm_data_i  = d;
    frm_count_i = 3'(cnt);
    frm_last_i  = lst;
    frm_valid_i = 1'b1;
    while (!frm_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    frm_valid_i = 1'b0;
    frm_data_i  = 56'({next_rand(), next_rand()});
    if (cnt != 0 || lst)
      chk(!frm_ready_o, "R4 ready low after taking frame", 16'(frm_ready_o), 16'h0);
    else
      chk(frm_ready_o, "R10 empty non-final frame passes", 16'(frm_ready_o), 16'h1);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(crc_o == 16'h0 && frm_ready_o && !done_o, "R7 start clears state",
        crc_o, 16'h0);
  endtask

  task automatic run_msg(input int n, input bit fixed7, output logic [15:0] got);
    int pos = 0;
    int k = 0;
    int lat;
    bit lst;
    logic [55:0] d;
    logic [15:0] exp = model_crc(n);
    if (n == 0) begin
      send_frame(56'({next_rand(), next_rand()}), 0, 1'b1);
    end else begin
      while (pos < n) begin
        if (!fixed7 && (next_rand() % 5 == 0))
          send_frame(56'({next_rand(), next_rand()}), 0, 1'b0);
        k = fixed7 ? 7 : 1 + int'(next_rand() % 7);
        if (k > n - pos) k = n - pos;
        lst = (pos + k == n);
        d = 56'({next_rand(), next_rand()});
        for (int j = 0; j < k; j++) d[8*j +: 8] = msg_a[pos + j];
        send_frame(d, k, lst);
        pos += k;
      end
    end
    lat = (n == 0) ? 2 : 8 * k + 8 * n + 1;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (c == lat - 1)
        chk(!done_o, (n == 0) ? "R8 done not early" : "R5 done not early",
            16'(done_o), 16'h0);
    end
    chk(done_o, (n == 0) ? "R8 done timing" : "R5 done timing", 16'(done_o), 16'h1);
    chk(crc_o == exp, (n == 0) ? "R8 empty message crc" : "R1 crc value", crc_o, exp);
    got = crc_o;
    @(negedge clk);
    chk(!done_o, "R6 done single pulse", 16'(done_o), 16'h0);
    repeat (2) @(negedge clk);
    chk(crc_o == got, "R6 crc held", crc_o, got);
    chk(!frm_ready_o, "R4 ready low after done", 16'(frm_ready_o), 16'h0);
    pulse_start();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_ready_o && !done_o && crc_o == 16'h0, "R9 reset state", crc_o, 16'h0);

    // known vector one: "123456789" arriving '9' first
    for (int i = 0; i < 9; i++) msg_a[i] = 8'h39 - 8'(i);
    run_msg(9, 1'b1, got);
    chk(got == 16'h31C3, "R1 known vector one", got, 16'h31C3);

    // known vector two
    begin
      logic [7:0] tail [0:8];
      tail = '{8'h21, 8'h83, 8'h04, 8'hFC, 8'h1C, 8'h9A, 8'h66, 8'h76, 8'h43};
      for (int i = 0; i < 9; i++) msg_a[i] = 8'h39 - 8'(i);
      for (int i = 0; i < 9; i++) msg_a[9 + i] = tail[i];
    end
    run_msg(18, 1'b1, got);
    chk(got == 16'h2848, "R1 known vector two", got, 16'h2848);

    // every single-byte message, garbage in unused lanes
    for (int v = 0; v < 256; v++) begin
      msg_a[0] = 8'(v);
      run_msg(1, 1'b0, got);
      chk(got == model_crc(1), "R2 unused lanes ignored", got, model_crc(1));
    end

    // lengths with random data and random frame splits
    for (int n = 2; n <= 40; n++)
      for (int rep = 0; rep < 3; rep++) begin
        for (int i = 0; i < n; i++) msg_a[i] = 8'(next_rand());
        run_msg(n, 1'b0, got);
      end

    // empty message
    run_msg(0, 1'b0, got);

    // start and frame offer in the same cycle: frame discarded
    frm_data_i  = 56'h11_2233_4455_6677;
    frm_count_i = 3'd3;
    frm_last_i  = 1'b1;
    frm_valid_i = 1'b1;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
    frm_valid_i = 1'b0;
    chk(frm_ready_o, "R7 R3 frame with start discarded", 16'(frm_ready_o), 16'h1);
    run_msg(0, 1'b0, got);

    // start lands during byte absorption
    for (int i = 0; i < 7; i++) msg_a[i] = 8'hC0 + 8'(i);
    send_frame({msg_a[6], msg_a[5], msg_a[4], msg_a[3], msg_a[2], msg_a[1], msg_a[0]},
               7, 1'b0);
    repeat (10) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 5; i++) msg_a[i] = 8'(next_rand());
    run_msg(5, 1'b0, got);
    chk(got == model_crc(5), "R7 fresh message after abort", got, model_crc(5));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule